// File: doc/BRIEF.md
# SPI Event Flags and Interrupt Combiner

This block sits beside an SPI controller and records the events that software has to react to. Each event has a sticky flag that stays set until software writes a 1 to it. The events are: a received word that overwrites unread data, a transmit request with nothing to send, a clock that arrives too slowly, the end of a transfer cycle, and the leading and trailing edges of the chip select.

The chip-select line is first passed through a synchronizer. A two-state tracker then follows it. `CS_IDLE` means the select is inactive. The transition `CS_IDLE -> CS_ACTIVE` happens when the synchronized line reaches its active level, and it emits a leading-edge pulse. The transition `CS_ACTIVE -> CS_IDLE` happens when the line returns to its inactive level, and it emits a trailing-edge pulse. Each state holds when the line does not change. A pin selects whether the active level is high or low.

The flags are masked one by one through an enable register. They are then ORed together and gated by a global enable pin, which produces a registered interrupt. A small register port reads the status and enable words and writes them. A soft-reset pin clears every sticky flag.

Top module: `spi_evt_irq`

## Requirements
- R1: Address 0 reads the status word. It holds the sticky flags at these bits: 2 read overflow, 3 select leading edge, 4 underclock, 5 cycle done, 6 select trailing edge, 8 write underflow. A flag becomes readable one cycle after its event and stays set until it is cleared.
- R2: A write to address 0 clears exactly the flags whose bits are 1 in the written data, starting from the next cycle. Bits written as 0 leave their flags unchanged.
- R3: A `rx_word` strobe while `rx_full` is 1 sets the read-overflow flag. A `rx_word` strobe while `rx_full` is 0 does not set it.
- R4: A `tx_need` strobe while `tx_full` is 0 sets the write-underflow flag. A `tx_need` strobe while `tx_full` is 1 does not set it.
- R5: The chip-select line passes through two synchronizing flops. An inactive-to-active change sets the leading-edge flag, and an active-to-inactive change sets the trailing-edge flag. The active level is high when `cs_act_high` is 1 and low when it is 0. A flag is readable three cycles after the line changes. Reset treats the line as inactive.
- R6: A `uclk_evt` strobe sets the underclock flag, and a `cyc_done` strobe sets the cycle-done flag.
- R7: Status bit 9 reads `tx_full` and status bit 10 reads `rx_full`. Both are live, not sticky, and follow their inputs in the same cycle.
- R8: Address 1 is the enable register. Each enable sits at the same bit position as its flag. Bits that are not enables read 0, and addresses 2 and 3 read 0.
- R9: `irq` is registered. It equals `irq_glob_en` AND the OR of (flags AND enables), evaluated one cycle earlier.
- R10: Status bit 0 reads the OR of (flags AND enables) at once, whatever the value of `irq_glob_en`.
- R11: An event in the same cycle as a write-1 clear of its flag leaves the flag set.
- R12: `soft_rst` clears all sticky flags on the next edge and has priority over any event. The enable register keeps its value.
- R13: After reset, all flags, all enables and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Clears all sticky flags |
| irq_glob_en | input | 1 | Global interrupt enable |
| cs_act_high | input | 1 | 1: chip select active high, 0: active low |
| cs_line | input | 1 | Asynchronous chip-select line |
| rx_word | input | 1 | Strobe: a received word is being stored |
| rx_full | input | 1 | Receive holding register holds an unread word |
| tx_need | input | 1 | Strobe: a word is needed for transmit |
| tx_full | input | 1 | Transmit holding register is occupied |
| cyc_done | input | 1 | Strobe: transfer cycle finished |
| uclk_evt | input | 1 | Strobe: underclock detected |
| reg_addr | input | 2 | Register address (0 status, 1 enable) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt output |

## Verification
The hardest case to reach from the ports is a collision: an event lands in the same edge as a write-1 clear or a soft reset of that same flag, while the chip-select tracker is in the middle of its three-cycle latency. Directed steps force a received word to coincide with a clear of the read-overflow flag, and count the edges between a select change and its flag. A long seeded random phase then mixes strobes, clears, soft resets, enable writes and select toggles densely enough that all of these overlaps occur many times. A cycle-accurate model in the bench compares the read data and the interrupt on every cycle.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
    localparam int REG_W      = 16;
    localparam int REG_ADDR_W = 2;

    localparam int B_PEND  = 0;
    localparam int B_RDOFL = 2;
    localparam int B_LEAD  = 3;
    localparam int B_UCLK  = 4;
    localparam int B_CYC   = 5;
    localparam int B_TRAIL = 6;
    localparam int B_WRUFL = 8;
    localparam int B_TXF   = 9;
    localparam int B_RXF   = 10;

    localparam logic [REG_W-1:0] FLAG_MASK =
        (REG_W'(1) << B_RDOFL) | (REG_W'(1) << B_LEAD) | (REG_W'(1) << B_UCLK) |
        (REG_W'(1) << B_CYC)   | (REG_W'(1) << B_TRAIL) | (REG_W'(1) << B_WRUFL);

    typedef enum logic {
        CS_IDLE   = 1'b0,
        CS_ACTIVE = 1'b1
    } cs_state_e;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1
    } reg_sel_e;
endpackage

// File: rtl/spi_cs_tracker.sv
module spi_cs_tracker
    import spi_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act_high,
    input  logic cs_line,
    output logic lead_pulse,
    output logic trail_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   idle_lvl;
    logic                   cs_active;
    cs_state_e              state_q, state_d;

    assign idle_lvl = ~cs_act_high;

    // synchronizer chain, preloaded with the inactive level
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= idle_lvl;
                else        sync_q <= cs_line;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= {SYNC_STAGES{idle_lvl}};
                else        sync_q <= {sync_q[LAST-1:0], cs_line};
            end
        end
    endgenerate

    assign cs_active = cs_act_high ? sync_q[LAST] : ~sync_q[LAST];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:   if (cs_active)  state_d = CS_ACTIVE;
            CS_ACTIVE: if (!cs_active) state_d = CS_IDLE;
            default:                   state_d = CS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        lead_pulse  = 1'b0;
        trail_pulse = 1'b0;
        unique case (state_q)
            CS_IDLE:   lead_pulse  = cs_active;
            CS_ACTIVE: trail_pulse = ~cs_active;
            default: ;
        endcase
    end

    p_edges_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lead_pulse, trail_pulse}));
    p_lead_enters_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pulse |=> (state_q == CS_ACTIVE));
    p_trail_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trail_pulse |=> (state_q == CS_IDLE));
endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags_q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (MASK[i]) begin : g_flag
                always_ff @(posedge clk) begin
                    if (!rst_n || soft_rst) flags_q[i] <= 1'b0;
                    else                    flags_q[i] <= set_vec[i] | (flags_q[i] & ~clr_vec[i]);
                end
            end else begin : g_none
                assign flags_q[i] = 1'b0;
            end
        end
    endgenerate

    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && clr_vec == '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((flags_q & $past(set_vec & MASK)) == $past(set_vec & MASK)));
    p_soft_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (flags_q == '0));
endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq
    import spi_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  irq_glob_en,
    input  logic                  cs_act_high,
    input  logic                  cs_line,
    input  logic                  rx_word,
    input  logic                  rx_full,
    input  logic                  tx_need,
    input  logic                  tx_full,
    input  logic                  cyc_done,
    input  logic                  uclk_evt,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  irq
);
    logic             lead_pulse, trail_pulse;
    logic [REG_W-1:0] set_vec, clr_vec, flags_q, en_q, status;
    logic             pending, irq_q;

    spi_cs_tracker #(.SYNC_STAGES(SYNC_STAGES)) u_cs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act_high (cs_act_high),
        .cs_line     (cs_line),
        .lead_pulse  (lead_pulse),
        .trail_pulse (trail_pulse)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[B_RDOFL] = rx_word & rx_full;
        set_vec[B_WRUFL] = tx_need & ~tx_full;
        set_vec[B_UCLK]  = uclk_evt;
        set_vec[B_CYC]   = cyc_done;
        set_vec[B_LEAD]  = lead_pulse;
        set_vec[B_TRAIL] = trail_pulse;
    end

    assign clr_vec = (reg_wr && reg_addr == SEL_STATUS) ? (reg_wdata & FLAG_MASK) : '0;

    spi_flag_bank #(.W(REG_W), .MASK(FLAG_MASK)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .flags_q  (flags_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else if (reg_wr && reg_addr == SEL_ENABLE) en_q <= reg_wdata & FLAG_MASK;
    end

    assign pending = |(flags_q & en_q);

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_glob_en & pending;
    end
    assign irq = irq_q;

    always_comb begin
        status         = flags_q;
        status[B_PEND] = pending;
        status[B_TXF]  = tx_full;
        status[B_RXF]  = rx_full;
    end

    always_comb begin
        case (reg_addr)
            SEL_STATUS: reg_rdata = status;
            SEL_ENABLE: reg_rdata = en_q;
            default:    reg_rdata = '0;
        endcase
    end

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word && rx_full && !soft_rst) |=> flags_q[B_RDOFL]);
    p_ufl_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_need && !tx_full && !soft_rst) |=> flags_q[B_WRUFL]);
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_glob_en |=> !irq);
    p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_glob_en && pending) |=> irq);
    p_en_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !reg_wr) |=> $stable(en_q));
endmodule

// File: tb/test_spi_evt_irq.sv
module test_spi_evt_irq;
    import spi_evt_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, soft_rst, irq_glob_en, cs_act_high, cs_line;
    logic rx_word, rx_full, tx_need, tx_full, cyc_done, uclk_evt;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        irq;

    spi_evt_irq i_spi_evt_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .irq_glob_en(irq_glob_en),
        .cs_act_high(cs_act_high), .cs_line(cs_line), .rx_word(rx_word),
        .rx_full(rx_full), .tx_need(tx_need), .tx_full(tx_full),
        .cyc_done(cyc_done), .uclk_evt(uclk_evt), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    localparam logic [15:0] M = 16'h017C;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_flags, m_en;
    logic        m_irq, m_s1, m_s2, m_act;

    function automatic logic [15:0] exp_rdata();
        logic [15:0] s;
        case (reg_addr)
            2'd0: begin
                s = m_flags;
                s[0] = |(m_flags & m_en);
                s[9] = tx_full;
                s[10] = rx_full;
                return s;
            end
            2'd1: return m_en;
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        soft_rst = 0; rx_word = 0; tx_need = 0; cyc_done = 0; uclk_evt = 0;
        reg_wr = 0; reg_wdata = 16'h0; reg_addr = 2'd0;
    endtask

    task automatic step();
        logic act;
        logic [15:0] st, cl, nf, ne;
        logic ni;
        act = cs_act_high ? m_s2 : ~m_s2;
        st = 16'h0;
        st[2] = rx_word & rx_full;
        st[8] = tx_need & ~tx_full;
        st[4] = uclk_evt;
        st[5] = cyc_done;
        st[3] = act & ~m_act;
        st[6] = ~act & m_act;
        cl = (reg_wr && reg_addr == 2'd0) ? (reg_wdata & M) : 16'h0;
        nf = soft_rst ? 16'h0 : ((m_flags & ~cl) | st);
        ne = (reg_wr && reg_addr == 2'd1) ? (reg_wdata & M) : m_en;
        ni = irq_glob_en & (|(m_flags & m_en));
        @(posedge clk);
        m_flags = nf; m_en = ne; m_irq = ni;
        m_s2 = m_s1; m_s1 = cs_line; m_act = act;
        @(negedge clk);
        chk("R9 irq", {15'h0, irq}, {15'h0, m_irq});
        chk("R1 read", reg_rdata, exp_rdata());
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; idle_in();
        irq_glob_en = 0; cs_act_high = 0; cs_line = 1; rx_full = 0; tx_full = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_flags = 0; m_en = 0; m_irq = 0; m_s1 = 1; m_s2 = 1; m_act = 0;
        // R13 reset state
        chk("R13 status", reg_rdata, 16'h0000);
        chk("R13 irq", {15'h0, irq}, 16'h0);
        reg_addr = 2'd1; #1;
        chk("R13 enable", reg_rdata, 16'h0000);
        reg_addr = 2'd0;

        // R7 live bits
        tx_full = 1; #1;
        chk("R7 txfull", reg_rdata, 16'h0200);
        rx_full = 1; tx_full = 0; #1;
        chk("R7 rxfull", reg_rdata, 16'h0400);

        // R3
        rx_full = 0; rx_word = 1; step(); rx_word = 0;
        chk("R3 no overflow", {15'h0, reg_rdata[2]}, 16'h0);
        rx_full = 1; rx_word = 1; step(); rx_word = 0;
        chk("R3 overflow", {15'h0, reg_rdata[2]}, 16'h1);

        // R4
        tx_full = 1; tx_need = 1; step(); tx_need = 0;
        chk("R4 no underflow", {15'h0, reg_rdata[8]}, 16'h0);
        tx_full = 0; tx_need = 1; step(); tx_need = 0;
        chk("R4 underflow", {15'h0, reg_rdata[8]}, 16'h1);

        // R6
        uclk_evt = 1; step(); uclk_evt = 0;
        chk("R6 underclock", {15'h0, reg_rdata[4]}, 16'h1);
        cyc_done = 1; step(); cyc_done = 0;
        chk("R6 cycle done", {15'h0, reg_rdata[5]}, 16'h1);

        // R2
        reg_wr = 1; reg_wdata = 16'h0000; step(); reg_wr = 0;
        chk("R2 zero write keeps", reg_rdata & M, 16'h0134);
        reg_wr = 1; reg_wdata = 16'h0004; step(); reg_wr = 0;
        chk("R2 clear one", reg_rdata & M, 16'h0130);

        // R11
        rx_word = 1; rx_full = 1; reg_wr = 1; reg_wdata = 16'h0004; step();
        rx_word = 0; reg_wr = 0;
        chk("R11 event beats clear", {15'h0, reg_rdata[2]}, 16'h1);

        // R8
        reg_addr = 2'd1; reg_wr = 1; reg_wdata = 16'hFFFF; step(); reg_wr = 0;
        chk("R8 enable mask", reg_rdata, 16'h017C);
        reg_addr = 2'd3; #1;
        chk("R8 unused addr", reg_rdata, 16'h0000);
        reg_addr = 2'd0;

        // R10 and R9
        irq_glob_en = 0; step();
        chk("R10 pending bit", {15'h0, reg_rdata[0]}, 16'h1);
        chk("R9 gated", {15'h0, irq}, 16'h0);
        irq_glob_en = 1; step();
        chk("R9 raised", {15'h0, irq}, 16'h1);

        // R5 edges, active low then active high
        reg_wr = 1; reg_wdata = 16'hFFFF; step(); reg_wr = 0;
        cs_line = 0; step(); step();
        chk("R5 lead latency", {15'h0, reg_rdata[3]}, 16'h0);
        step();
        chk("R5 lead", {15'h0, reg_rdata[3]}, 16'h1);
        cs_line = 1; step(); step(); step();
        chk("R5 trail", {15'h0, reg_rdata[6]}, 16'h1);
        reg_wr = 1; reg_wdata = 16'hFFFF; step(); reg_wr = 0;
        cs_act_high = 1; step();
        chk("R5 polarity lead", {15'h0, reg_rdata[3]}, 16'h1);

        // R12
        uclk_evt = 1; soft_rst = 1; step(); soft_rst = 0; uclk_evt = 0;
        chk("R12 flags cleared", reg_rdata & M, 16'h0000);
        reg_addr = 2'd1; #1;
        chk("R12 enables kept", reg_rdata, 16'h017C);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            rx_word  = ($urandom % 6) == 0;
            tx_need  = ($urandom % 6) == 0;
            cyc_done = ($urandom % 10) == 0;
            uclk_evt = ($urandom % 12) == 0;
            rx_full  = ($urandom % 2) == 0;
            tx_full  = ($urandom % 2) == 0;
            soft_rst = ($urandom % 64) == 0;
            reg_wr   = ($urandom % 5) == 0;
            reg_addr = 2'($urandom % 4);
            reg_wdata = 16'($urandom);
            if (($urandom % 16) == 0) irq_glob_en = ~irq_glob_en;
            if (($urandom % 8) == 0) cs_line = ~cs_line;
            if (($urandom % 300) == 0) cs_act_high = ~cs_act_high;
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule